// File: doc/BRIEF.md
# Dual-Clock FIFO with Sequenced Reset

This block carries data words from a write clock domain to a read clock domain when the two clocks have no frequency or phase relationship. Words enter through a write port (data, write enable, full flag) clocked by the write clock. They leave through a read port (read enable, data, empty flag) clocked by the read clock. Each side keeps a binary pointer one bit wider than the storage address. It sends the Gray-coded form of that pointer to the other side through a chain of two flip-flops, and compares it there to decide whether the buffer is full or empty.

The block takes one raw asynchronous reset and produces its own reset for each domain. Each domain reset asserts at once and releases through a two-stage chain clocked by that domain's clock. Both status flags are forced high while reset is active, so the user logic on either side cannot write or read. The full flag also stays high for a programmable number of write cycles after the write side leaves reset. This gives a slower read side time to leave reset before any word is stored. Each flag releases only on its own clock.

Top module: `dualclk_fifo`

## Requirements
- R1: Words come out in the order they were accepted, with their values unchanged. A read is accepted at a rising read edge where `rd_en` is 1 and `rd_empty` is 1'b0. Its word is on `rd_data` after that same edge, so it can be sampled in the following read cycle.
- R2: `rd_data` keeps its value across every read cycle with no accepted read.
- R3: While `arst_i` is high, `wr_full` and `rd_empty` are both 1. Both go to 1 as soon as `arst_i` rises, without waiting for a clock edge.
- R4: `arst_i` is released between write edges. `wr_full` then reads 1 after each of the first HOLD_CYC+1 rising write edges. If no word is stored, it reads 0 after the (HOLD_CYC+2)-th edge. Two of these edges are the release chain of the write-domain reset; the other HOLD_CYC are the hold-off window.
- R5: After reset, `rd_empty` stays 1 until a word has been written. A single write into an empty buffer clears `rd_empty` after the 3rd or 4th rising read edge that follows the write edge.
- R6: A write is accepted only at a rising write edge where `wr_en` is 1 and `wr_full` is 0. Writes made while `wr_full` is 1, including during reset and the hold-off window, store nothing and leave the write pointer unchanged.
- R7: A read attempted while `rd_empty` is 1 is ignored. It does not move the read pointer, so the next word written is the next word read.
- R8: `wr_full` is 1 whenever DEPTH words are held. `rd_empty` is 1 whenever no word is held.
- R9: Once both ports have been idle for 8 cycles of each clock, `wr_full` is 1 exactly when DEPTH words are held, and `rd_empty` is 1 exactly when none are held.
- R10: A reset pulse during traffic discards every stored word. The first word read after the reset is the first word accepted after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock, asynchronous to `wr_clk` |
| arst_i | input | 1 | Raw asynchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | Buffer full or write side held in reset or hold-off |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Registered word from the last accepted read |
| rd_empty | output | 1 | No word available or read side held in reset |

## Verification
Each flag must follow its trigger by a known number of edges. `wr_full` rises on the write edge that stores the DEPTH-th word. `rd_empty` falls three read edges after a write edge: two synchronizer stages and the flag register. `rd_data` is valid after the very edge that accepts a read. After reset release, `wr_full` must stay high for exactly HOLD_CYC+1 write edges. The bench decides acceptance at the falling edge before each rising edge, from the flag value held since the last rising edge. It checks the result at the next falling edge. Because crossing latency lets a flag lag in the safe direction only, the bench checks R8 as an implication on every cycle. It checks the exact values of R9 only after idle windows longer than the worst crossing delay.

// File: rtl/dualclk_fifo_pkg.sv
`timescale 1ns/1ps
package dualclk_fifo_pkg;

  // Write-side start-up phases: held in reset, counting the hold-off window, running
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_RUN  = 2'd2
  } wr_phase_e;

endpackage

// File: rtl/dualclk_fifo_rst_sync.sv
`timescale 1ns/1ps
// Domain reset: asserted asynchronously, released after STAGES edges of clk
module dualclk_fifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_i,
  output logic rst_o
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge arst_i) begin
    if (arst_i) begin
      chain <= '1;
    end else begin
      chain <= {chain[STAGES-2:0], 1'b0};
    end
  end

  assign rst_o = chain[STAGES-1];

endmodule

// File: rtl/dualclk_fifo_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for a Gray-coded pointer bus
module dualclk_fifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or posedge rst) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or posedge rst) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dualclk_fifo_wr.sv
`timescale 1ns/1ps
// Write-side pointer, hold-off sequencing and registered full flag
module dualclk_fifo_wr
  import dualclk_fifo_pkg::*;
#(
  parameter int AW       = 4,
  parameter int HOLD_CYC = 4   // must be at least 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_sync,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          wr_fire,
  output logic          full
);

  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [AW:0]   wbin, wbin_nx, wgray_nx, full_pat;
  wr_phase_e     phase, phase_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          full_nx;

  assign wr_fire  = wr_en & ~full;
  assign wbin_nx  = wbin + {{AW{1'b0}}, wr_fire};
  assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
  // Read pointer one lap behind: top two Gray bits inverted, the rest equal
  assign full_pat = {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]};
  assign waddr    = wbin[AW-1:0];

  always_comb begin
    phase_nx = phase;
    cnt_nx   = cnt;
    if (phase != PH_RUN) begin
      cnt_nx   = cnt + 1'b1;
      phase_nx = (cnt_nx >= CW'(HOLD_CYC)) ? PH_RUN : PH_HOLD;
    end
    full_nx = (phase_nx != PH_RUN) | (wgray_nx == full_pat);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      phase <= PH_IDLE;
      cnt   <= '0;
      full  <= 1'b1;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      phase <= phase_nx;
      cnt   <= cnt_nx;
      full  <= full_nx;
    end
  end

endmodule

// File: rtl/dualclk_fifo_rd.sv
`timescale 1ns/1ps
// Read-side pointer and registered empty flag
module dualclk_fifo_rd #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_sync,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          rd_fire,
  output logic          empty
);

  logic [AW:0] rbin, rbin_nx, rgray_nx;

  assign rd_fire  = rd_en & ~empty;
  assign rbin_nx  = rbin + {{AW{1'b0}}, rd_fire};
  assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      empty <= 1'b1;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rgray_nx;
      empty <= (rgray_nx == wgray_sync);
    end
  end

endmodule

// File: rtl/dualclk_fifo_ram.sv
`timescale 1ns/1ps
// Simple dual-port storage: write on one clock, registered read on the other
module dualclk_fifo_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or posedge rrst) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/dualclk_fifo.sv
`timescale 1ns/1ps
module dualclk_fifo #(
  parameter int DW          = 8,
  parameter int DEPTH       = 16,  // power of two, at least 4
  parameter int HOLD_CYC    = 4,   // write-side hold-off after reset, at least 1
  parameter int SYNC_STAGES = 2    // pointer synchronizer depth
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          arst_i,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty
);

  localparam int AW = $clog2(DEPTH);

  logic          wr_rst_s, rd_rst_s;
  logic [AW:0]   wgray_w, rgray_r, rgray_at_w, wgray_at_r;
  logic [AW-1:0] waddr, raddr;
  logic          wr_fire, rd_fire;

  dualclk_fifo_rst_sync #(.STAGES(2)) u_wrst (
    .clk(wr_clk), .arst_i(arst_i), .rst_o(wr_rst_s)
  );

  dualclk_fifo_rst_sync #(.STAGES(2)) u_rrst (
    .clk(rd_clk), .arst_i(arst_i), .rst_o(rd_rst_s)
  );

  dualclk_fifo_wr #(.AW(AW), .HOLD_CYC(HOLD_CYC)) u_wr (
    .clk(wr_clk), .rst(wr_rst_s), .wr_en(wr_en), .rgray_sync(rgray_at_w),
    .wgray(wgray_w), .waddr(waddr), .wr_fire(wr_fire), .full(wr_full)
  );

  dualclk_fifo_rd #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst(rd_rst_s), .rd_en(rd_en), .wgray_sync(wgray_at_r),
    .rgray(rgray_r), .raddr(raddr), .rd_fire(rd_fire), .empty(rd_empty)
  );

  dualclk_fifo_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst(wr_rst_s), .d(rgray_r), .q(rgray_at_w)
  );

  dualclk_fifo_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst(rd_rst_s), .d(wgray_w), .q(wgray_at_r)
  );

  dualclk_fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst(rd_rst_s), .re(rd_fire), .raddr(raddr), .rdata(rd_data)
  );

endmodule

// File: rtl/dualclk_fifo_chk.sv
`timescale 1ns/1ps
module dualclk_fifo_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_rst,
  input logic          rd_rst,
  input logic          wr_en,
  input logic          wr_full,
  input logic          rd_en,
  input logic          rd_empty,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rgray
);

  // R3: flags held high while each domain is in reset
  a_r3_full_in_reset: assert property (@(posedge wr_clk) wr_rst |-> wr_full);
  a_r3_empty_in_reset: assert property (@(posedge rd_clk) rd_rst |-> rd_empty);

  // R4: full still high on the first edge after the write-domain reset releases
  a_r4_full_after_release: assert property (@(posedge wr_clk) $fell(wr_rst) |-> wr_full);

  // R6: a refused write leaves the write pointer where it was
  a_r6_wptr_frozen_when_full: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_en && wr_full) |=> $stable(wgray));

  // R7: a refused read leaves the read pointer where it was
  a_r7_rptr_frozen_when_empty: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && rd_empty) |=> $stable(rgray));

  // R2: output word held when no read is accepted
  a_r2_rdata_hold: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !(rd_en && !rd_empty) |=> $stable(rd_data));

  // R1: crossing pointers move by at most one Gray bit per cycle
  a_r1_wgray_one_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(wgray ^ $past(wgray)) <= 1);
  a_r1_rgray_one_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $countones(rgray ^ $past(rgray)) <= 1);

endmodule

bind dualclk_fifo dualclk_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst(wr_rst_s), .rd_rst(rd_rst_s),
  .wr_en(wr_en), .wr_full(wr_full), .rd_en(rd_en), .rd_empty(rd_empty),
  .rd_data(rd_data), .wgray(wgray_w), .rgray(rgray_r)
);

// File: tb/dualclk_fifo_bench.sv
`timescale 1ns/1ps
module dualclk_fifo_bench;

  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int HOLD  = 4;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          arst;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          full, empty;
  logic [DW-1:0] rd_data;

  int  n_tests = 0;
  int  n_fail  = 0;
  real rd_half = 5.5;

  logic [DW-1:0] exp_q [$];
  int            wr_pct  = 0;
  int            rd_pct  = 0;
  bit            wr_once = 1'b0;
  logic [DW-1:0] next_val = 8'h10;

  dualclk_fifo #(.DW(DW), .DEPTH(DEPTH), .HOLD_CYC(HOLD), .SYNC_STAGES(2)) u_dualclk_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_i(arst),
    .wr_en(wr_en), .wr_data(wr_data), .wr_full(full),
    .rd_en(rd_en), .rd_data(rd_data), .rd_empty(empty)
  );

  always #4 wr_clk = ~wr_clk;   // 125 MHz
  initial begin
    #0.3;
    forever #(rd_half) rd_clk = ~rd_clk;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Write-side reference model: acceptance decided from the flag held since the last edge
  initial begin
    bit want;
    forever begin
      @(negedge wr_clk);
      if (arst === 1'b0 && exp_q.size() == DEPTH)
        check(full === 1'b1, "R8", "full with DEPTH words", int'(full), 1);
      want    = wr_once || ($urandom_range(99) < wr_pct);
      wr_once = 1'b0;
      wr_en   = want;
      wr_data = next_val;
      if (want && full === 1'b0) begin
        exp_q.push_back(next_val);
        next_val = next_val + 1'b1;
      end
    end
  end

  // Read-side reference model: data due one read cycle after acceptance
  initial begin
    bit            want;
    bit            racc = 1'b0;
    bit            have_last = 1'b0;
    logic [DW-1:0] rexp = '0;
    logic [DW-1:0] last = '0;
    forever begin
      @(negedge rd_clk);
      if (arst !== 1'b0) begin
        racc      = 1'b0;
        have_last = 1'b0;
      end else begin
        if (racc) begin
          check(rd_data === rexp, "R1", "read word", int'(rd_data), int'(rexp));
          last      = rexp;
          have_last = 1'b1;
        end else if (have_last) begin
          check(rd_data === last, "R2", "held read word", int'(rd_data), int'(last));
        end
        if (exp_q.size() == 0)
          check(empty === 1'b1, "R8", "empty with no words", int'(empty), 1);
      end
      want  = ($urandom_range(99) < rd_pct);
      rd_en = want;
      racc  = 1'b0;
      if (arst === 1'b0 && want && empty === 1'b0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "read accepted with nothing stored", 1, 0);
        end else begin
          rexp = exp_q.pop_front();
          racc = 1'b1;
        end
      end
    end
  end

  task automatic run(input int wp, input int rp, input int cycles);
    wr_pct = wp;
    rd_pct = rp;
    repeat (cycles) @(negedge wr_clk);
  endtask

  task automatic settle(input string tag);
    wr_pct = 0;
    rd_pct = 0;
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
    check(full === (exp_q.size() == DEPTH), tag, "settled full", int'(full),
          int'(exp_q.size() == DEPTH));
    check(empty === (exp_q.size() == 0), tag, "settled empty", int'(empty),
          int'(exp_q.size() == 0));
  endtask

  task automatic assert_reset();
    @(negedge wr_clk);
    #1.3;
    arst = 1'b1;
    exp_q.delete();
    #0.2;
    check(full === 1'b1, "R3", "full right after reset rises", int'(full), 1);
    check(empty === 1'b1, "R3", "empty right after reset rises", int'(empty), 1);
    repeat (3) begin
      @(negedge wr_clk);
      check(full === 1'b1 && empty === 1'b1, "R3", "flags during reset",
            int'({full, empty}), 3);
    end
  endtask

  task automatic release_check();
    @(negedge wr_clk);
    arst = 1'b0;
    for (int i = 0; i < HOLD + 1; i++) begin
      @(negedge wr_clk);
      check(full === 1'b1, "R4", "full during release and hold-off", int'(full), 1);
    end
    @(negedge wr_clk);
    check(full === 1'b0, "R4", "full after hold-off", int'(full), 0);
  endtask

  task automatic latency_check();
    int n;
    @(posedge wr_clk);
    #1;
    wr_once = 1'b1;
    @(negedge wr_clk);
    @(posedge wr_clk);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge rd_clk);
      #0.2;
      n++;
      if (empty === 1'b0) break;
    end
    check(n >= 3 && n <= 4, "R5", "read edges until empty falls", n, 3);
  endtask

  initial begin
    arst = 1'b1;
    #1;
    check(full === 1'b1, "R3", "full at start of reset", int'(full), 1);
    check(empty === 1'b1, "R3", "empty at start of reset", int'(empty), 1);
    repeat (3) @(negedge wr_clk);
    release_check();
    settle("R5");

    latency_check();
    settle("R5");
    run(0, 100, 10);
    settle("R9");

    run(0, 100, 20);          // reads on an empty buffer
    wr_once = 1'b1;
    settle("R7");
    run(0, 100, 10);
    settle("R7");

    run(100, 0, 40);          // fill, then keep writing into a full buffer
    settle("R6");
    run(0, 100, 40);
    settle("R6");

    run(60, 60, 600);
    run(80, 40, 600);
    run(30, 90, 600);
    settle("R9");
    rd_half = 3.1;
    run(70, 70, 800);
    run(95, 20, 300);
    run(20, 95, 300);
    settle("R9");
    rd_half = 9.0;
    run(50, 90, 400);
    run(90, 50, 400);
    settle("R9");

    run(70, 30, 100);         // reset in the middle of traffic
    wr_pct = 100;
    rd_pct = 0;
    assert_reset();
    release_check();
    run(0, 0, 2);
    settle("R10");
    run(0, 100, 80);
    settle("R10");
    run(60, 60, 300);
    settle("R9");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule